// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers the event sources of a serial port into one interrupt line. Each source has a sticky status bit, which is set by a one-cycle event pulse and stays set until software writes 1 to it. Software opens a source by writing 1 to the enable port and closes it by writing 1 to the disable port. The mask built up this way can be read back. The interrupt line is high while any status bit is set whose mask bit is also set.

Twelve sources arrive as event pulses. The thirteenth, the receive-level trigger, is made inside the block. It fires whenever the receive FIFO fill level is at or above a programmable water mark. The block has a simple register port with one write strobe, one read strobe, a byte address and write data. Read data is combinational from the registers.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset the mask and the status are all zero, the water mark reads 32 and `irq_o` is low.
- R2: A write to offset 0x08 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. The mask reads back at offset 0x10 in bits 12:0. Reads of offset 0x08, offset 0x0C and unmapped offsets return zero.
- R3: A write to offset 0x0C clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A set status bit stays set until a write to offset 0x14 has a 1 in that bit position. Status bits written with 0 keep their value, and idle cycles change nothing.
- R5: An event pulse sets its status bit at the next clock edge, whether or not the source is masked. `evt_i[k-1]` drives status bit k for k = 1..12: tx overflow is 12, tx nearly full 11, tx trigger 10, modem-status delta 9, rx timeout 8, parity 7, framing 6, rx overflow 5, tx full 4, tx empty 3, rx full 2 and rx empty 1.
- R6: If a status bit is set and cleared in the same cycle, it stays set.
- R7: `irq_o` is the OR over all bits of (status AND mask). It follows the registers with no extra cycle.
- R8: Status bit 0 (rx trigger) is set at every clock edge where the water mark is nonzero and `rx_level_i` is greater than or equal to it. The water mark is written and read at offset 0x20 in bits 6:0.
- R9: A water mark of zero turns the rx trigger off for every fill level.
- R10: Writes to unmapped offsets do nothing. Write data bits above bit 12 have no effect on the mask or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; read data is zero without it |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| evt_i | input | 12 | One-cycle event pulses for sources 12..1 |
| rx_level_i | input | 7 | Receive FIFO fill level, 0..64 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench clears a status bit in the same cycle as a new event for that bit. A design that let the clear win would lose the event, and the status read would miss the bit. It sweeps the fill level across the water mark and checks both sides. It also sets the water mark to zero and to 64, where an off-by-one compare or a missing zero check would raise the trigger at the wrong level. It writes disable bits that overlap an open mask and writes to unmapped offsets. A design that rewrote the whole mask or decoded too loosely would show a changed mask value or a changed interrupt line.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_SRC    = 13;
  localparam int FIFO_DEPTH = 64;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int WM_RESET   = FIFO_DEPTH / 2;
  localparam int SRC_RXTRIG = 0;

  localparam logic [7:0] OFS_EN   = 8'h08;
  localparam logic [7:0] OFS_DIS  = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_WM   = 8'h20;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg #(
  parameter int N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_ce;

  always_comb begin
    mask_d  = mask_q;
    mask_ce = set_we_i | clr_we_i;
    if (set_we_i) mask_d = mask_d | bits_i;
    if (clr_we_i) mask_d = mask_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  p_en_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

  p_dis_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((mask_o & $past(bits_i)) == '0));

  p_dis_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));
endmodule

// File: rtl/sirq_status_reg.sv
module sirq_status_reg #(
  parameter int N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_d;
    logic bit_ce;
    logic bit_clr;

    always_comb begin
      bit_clr = clr_we_i & clr_bits_i[b];
      bit_ce  = set_i[b] | bit_clr;
      // a new event outranks a clear in the same cycle
      bit_d   = set_i[b] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     status_q[b] <= 1'b0;
      else if (bit_ce) status_q[b] <= bit_d;
    end
  end

  assign status_o = status_q;

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((set_i & clr_bits_i) != '0)) |=>
      ((status_o & $past(set_i & clr_bits_i)) == $past(set_i & clr_bits_i)));

  p_event_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/sirq_rx_trig.sv
module sirq_rx_trig #(
  parameter int LVL_W    = 7,
  parameter int WM_RESET = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wm_we_i,
  input  logic [LVL_W-1:0] wm_wdata_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] wm_o,
  output logic             trig_o
);
  logic [LVL_W-1:0] wm_q;
  logic             wm_on;
  logic             at_mark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wm_q <= LVL_W'(WM_RESET);
    else if (wm_we_i) wm_q <= wm_wdata_i;
  end

  always_comb begin
    wm_on   = (wm_q != '0);
    at_mark = (level_i >= wm_q);
    trig_o  = wm_on & at_mark;
  end

  assign wm_o = wm_q;
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-2:0] evt_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              irq_o
);
  logic               rst_n;
  logic               en_we, dis_we, stat_we, wm_we;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] set_vec;
  logic [LVL_W-1:0]   wm;
  logic               rx_trig;
  logic               unused_wdata;

  sirq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    en_we   = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EN));
    dis_we  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_DIS));
    stat_we = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT));
    wm_we   = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_WM));
    wbits   = reg_wdata_i[NUM_SRC-1:0];
  end

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  sirq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .set_we_i (en_we),
    .clr_we_i (dis_we),
    .bits_i   (wbits),
    .mask_o   (mask)
  );

  sirq_rx_trig #(.LVL_W(LVL_W), .WM_RESET(WM_RESET)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wm_we_i    (wm_we),
    .wm_wdata_i (reg_wdata_i[LVL_W-1:0]),
    .level_i    (rx_level_i),
    .wm_o       (wm),
    .trig_o     (rx_trig)
  );

  assign set_vec = {evt_i, rx_trig};

  sirq_status_reg #(.N(NUM_SRC)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .set_i      (set_vec),
    .clr_we_i   (stat_we),
    .clr_bits_i (wbits),
    .status_o   (status)
  );

  assign irq_o = |(status & mask);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        ADDR_W'(OFS_MASK): reg_rdata_o = {{(DATA_W-NUM_SRC){1'b0}}, mask};
        ADDR_W'(OFS_STAT): reg_rdata_o = {{(DATA_W-NUM_SRC){1'b0}}, status};
        ADDR_W'(OFS_WM):   reg_rdata_o = {{(DATA_W-LVL_W){1'b0}}, wm};
        default:           reg_rdata_o = '0;
      endcase
    end
  end

  p_trig_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((wm != '0) && (rx_level_i >= wm)) |=> status[SRC_RXTRIG]);

  p_wm_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((wm == '0) && stat_we && wbits[SRC_RXTRIG]) |=> !status[SRC_RXTRIG]);

  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);

  p_nowrite_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_we && !dis_we) |=> $stable(mask));
endmodule

// File: tb/sirq_ctrl_tb_top.sv
module sirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [11:0] evt;
  logic [6:0]  lvl;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sirq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_i(evt), .rx_level_i(lvl), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [11:0] evt;
    logic [6:0]  lvl;
    logic [7:0]  raddr;
    logic [15:0] exp;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd0,  8'h10, 16'h0000, 1'b0, 4'd1},  // R1 idle
    '{1'b0, 8'h00, 16'h0000, 12'h004, 7'd0,  8'h14, 16'h0008, 1'b0, 4'd5},  // R5 masked tx empty sets
    '{1'b1, 8'h08, 16'h0008, 12'h000, 7'd0,  8'h10, 16'h0008, 1'b1, 4'd2},  // R2 R7 enable
    '{1'b1, 8'h14, 16'h0008, 12'h000, 7'd0,  8'h14, 16'h0000, 1'b0, 4'd4},  // R4 w1c
    '{1'b1, 8'h08, 16'h1FFF, 12'h000, 7'd0,  8'h10, 16'h1FFF, 1'b0, 4'd2},  // R2 all
    '{1'b1, 8'h0C, 16'h0006, 12'h000, 7'd0,  8'h10, 16'h1FF9, 1'b0, 4'd3},  // R3 partial
    '{1'b0, 8'h00, 16'h0000, 12'h801, 7'd0,  8'h14, 16'h1002, 1'b1, 4'd5},  // R5 two events
    '{1'b1, 8'h0C, 16'h1000, 12'h000, 7'd0,  8'h14, 16'h1002, 1'b0, 4'd7},  // R7 irq drops
    '{1'b1, 8'h14, 16'h0002, 12'h001, 7'd0,  8'h14, 16'h1002, 1'b0, 4'd6},  // R6 set wins
    '{1'b1, 8'h14, 16'h1FFF, 12'h000, 7'd0,  8'h14, 16'h0000, 1'b0, 4'd4},  // R4 clear all
    '{1'b1, 8'h20, 16'h0010, 12'h000, 7'd0,  8'h20, 16'h0010, 1'b0, 4'd8},  // R8 wm=16
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd15, 8'h14, 16'h0000, 1'b0, 4'd8},  // R8 below
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd16, 8'h14, 16'h0001, 1'b1, 4'd8},  // R8 at mark
    '{1'b1, 8'h14, 16'h0001, 12'h000, 7'd16, 8'h14, 16'h0001, 1'b1, 4'd6},  // R6 level holds
    '{1'b1, 8'h14, 16'h0001, 12'h000, 7'd3,  8'h14, 16'h0000, 1'b0, 4'd8},  // R8 cleared
    '{1'b1, 8'h20, 16'h0000, 12'h000, 7'd3,  8'h20, 16'h0000, 1'b0, 4'd9},  // R9 wm=0
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd64, 8'h14, 16'h0000, 1'b0, 4'd9},  // R9 full, off
    '{1'b1, 8'h20, 16'h0040, 12'h000, 7'd64, 8'h14, 16'h0000, 1'b0, 4'd8},  // R8 wm=64
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd64, 8'h14, 16'h0001, 1'b1, 4'd8},  // R8 full=mark
    '{1'b1, 8'h30, 16'hFFFF, 12'h000, 7'd0,  8'h10, 16'h0FF9, 1'b1, 4'd10}, // R10 unmapped
    '{1'b1, 8'h14, 16'h1FFF, 12'h000, 7'd0,  8'h14, 16'h0000, 1'b0, 4'd4},  // R4 clear
    '{1'b0, 8'h00, 16'h0000, 12'h000, 7'd0,  8'h08, 16'h0000, 1'b0, 4'd2}   // R2 en reads 0
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    wr = 1'b0; evt = '0; rd = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reset_chk();
    rd_chk("R1 mask", 8'h10, 32'h0);
    rd_chk("R1 status", 8'h14, 32'h0);
    rd_chk("R1 watermark", 8'h20, 32'd32);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    wr = 0; rd = 0; addr = 0; wdata = 0; evt = 0; lvl = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    reset_chk();  // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr = TBL[i].wr; addr = TBL[i].addr; wdata = {16'h0, TBL[i].wdata};
      evt = TBL[i].evt; lvl = TBL[i].lvl;
      @(negedge clk);
      wr = 1'b0; evt = '0; rd = 1'b1; addr = TBL[i].raddr;
      #1;
      n_chk++;
      if (rdata !== {16'h0, TBL[i].exp}) begin
        n_fail++;
        $display("FAIL vec %0d R%0d rdata got %h exp %h", i, TBL[i].req, rdata, TBL[i].exp);
      end
      n_chk++;
      if (irq !== TBL[i].exp_irq) begin
        n_fail++;
        $display("FAIL vec %0d R%0d irq got %b exp %b", i, TBL[i].req, irq, TBL[i].exp_irq);
      end
      rd = 1'b0;
    end

    // R5: every event line at once
    lvl = 7'd0;
    @(negedge clk) evt = 12'hFFF;
    rd_chk("R5 all events", 8'h14, 32'h1FFE);
    check("R7 irq with events", {31'b0, irq}, 32'h1);

    // R4: held through idle cycles
    repeat (20) @(negedge clk);
    rd_chk("R4 held", 8'h14, 32'h1FFE);

    // R10: upper data bits ignored
    wr_reg(8'h14, 32'hFFFF_E000);
    rd_chk("R10 status upper bits", 8'h14, 32'h1FFE);
    wr_reg(8'h0C, 32'hFFFF_E000);
    rd_chk("R10 mask upper bits", 8'h10, 32'h0FF9);

    // R1: asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_chk();

    // R2 R10: after reset, upper-bit enable write changes nothing
    wr_reg(8'h08, 32'hFFFF_E000);
    rd_chk("R10 enable upper bits", 8'h10, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule